// File: doc/BRIEF.md
# DRAM Power-Down Timing Sequencer

This block decides when one DRAM rank may go into power-down and runs the timed sequence that brings it back out. It sits beside a memory controller's command path and watches every command it lets through. Each command kind (read, write or any other kind) starts its own entry delay. A power-down request is remembered until all of those delays have run out and no command is being issued in that cycle. The rank then enters power-down.

Once down, the rank stays there for a minimum time made of a command-pass-disable interval followed by a minimum power-down width. A wake request that arrives during that time is kept and acted on when the time has passed. The exit first allows for the DRAM clock to restart. It then freezes the command/address bus for a setup window and pulses chip select low for a minimum width. Chip select goes back high for a minimum width that also covers the command/address hold after the rising edge. Commands stay blocked for an exit-to-command recovery time before the controller may issue again.

Every interval is read from one 64-bit configuration word. The word is captured only while the sequencer is idle, so a change made during a power-down cycle takes effect on the next one.

Top module: `pdseq_top`

## Requirements
- R1: After reset, `cmd_allow` is 1, `cs_n` is 1, `pd_active` is 0 and `ca_hold` is 0.
- R2: A read is `cmd_type` 2'b00. After a read accepted at clock edge k, power-down entry (`pd_active` rising) happens no earlier than edge k+N+1. N is the read-to-power-down field, bits 26:19.
- R3: A write is `cmd_type` 2'b01. After a write accepted at edge k, entry happens no earlier than edge k+N+1. N is the write-to-power-down field, bits 36:27.
- R4: Any other command is `cmd_type` 2'b10 or 2'b11. After such a command accepted at edge k, entry happens no earlier than edge k+N+1. N is the other-command-to-power-down field, bits 63:59.
- R5: A one-cycle `pd_req` pulse is remembered while idle. Entry happens at the first edge where every pending entry delay has expired and `cmd_valid` is low. A command issued while a request waits restarts the delay for its own kind.
- R6: From entry, `pd_active` stays 1 and `cmd_allow` stays 0 for at least max(P,1)+max(K,1) cycles and until a wake request. P is bits 18:14 and K is bits 6:0. A wake pulse during that time is kept.
- R7: Once the exit starts, `pd_active` stays 1 with `ca_hold` 0 for max(C,1) cycles, where C is bits 41:37. Then `ca_hold` is 1 with `cs_n` high for max(S,1) cycles before `cs_n` falls, where S is bits 58:54.
- R8: `cs_n` is low for max(L,1) cycles, where L is bits 53:48. `ca_hold` and `pd_active` stay 1 throughout.
- R9: After `cs_n` rises, `ca_hold` and `pd_active` stay 1 for max(H,S,1) cycles. H is bits 47:42.
- R10: After that, `pd_active` and `cmd_allow` are both 0 for max(X,1) cycles, where X is bits 13:7. Then `cmd_allow` returns to 1.
- R11: An entry-delay field of zero adds no wait. A sequence field of zero gives a one-cycle phase.
- R12: While `cmd_allow` is 0, commands, power-down requests and configuration changes have no effect on the current sequence or on the next entry. A new configuration word applies from the next idle period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 64 | Packed timing configuration word |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | Kind of the issued command |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| pd_active | output | 1 | Rank is in power-down or in its exit pulse |
| cs_n | output | 1 | Chip select, active low |
| ca_hold | output | 1 | Command/address bus must stay frozen |
| cmd_allow | output | 1 | Controller may issue commands |

## Verification
The bench builds the block with the default timer width of 10 bits. That is the narrowest width that holds the widest field, so a write-to-power-down value of 1023 and all-ones values in every other field can be exercised without truncation. With that width, the table of configuration vectors reaches each field at zero, at a small value and at its top value. This shows the one-cycle floor of the phases and the case where the command/address hold, not the chip-select high width, sets the length of the high phase. The directed part covers a delayed wake, a delay restarted by a later command, a request in the same cycle as a command, and configuration or commands presented while blocked.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  localparam int unsigned CFG_W     = 64;
  localparam int unsigned NUM_KINDS = 3;

  // Field placement inside the configuration word
  localparam int unsigned F_PR_LSB    = 59;  localparam int unsigned F_PR_W    = 5;
  localparam int unsigned F_CACSH_LSB = 54;  localparam int unsigned F_CACSH_W = 5;
  localparam int unsigned F_CSL_LSB   = 48;  localparam int unsigned F_CSL_W   = 6;
  localparam int unsigned F_CSH_LSB   = 42;  localparam int unsigned F_CSH_W   = 6;
  localparam int unsigned F_CKH_LSB   = 37;  localparam int unsigned F_CKH_W   = 5;
  localparam int unsigned F_WR_LSB    = 27;  localparam int unsigned F_WR_W    = 10;
  localparam int unsigned F_RD_LSB    = 19;  localparam int unsigned F_RD_W    = 8;
  localparam int unsigned F_CPD_LSB   = 14;  localparam int unsigned F_CPD_W   = 5;
  localparam int unsigned F_XP_LSB    = 7;   localparam int unsigned F_XP_W    = 7;
  localparam int unsigned F_CKE_LSB   = 0;   localparam int unsigned F_CKE_W   = 7;

  localparam logic [1:0] CMD_RD = 2'b00;
  localparam logic [1:0] CMD_WR = 2'b01;

  typedef enum logic [2:0] {
    PH_CPDED, PH_CKE, PH_CKCKEH, PH_CACSH, PH_CSL, PH_CSHI, PH_XP
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_DOWN, ST_CLKWAIT, ST_SETUP, ST_CSLOW, ST_CSHIGH, ST_RECOVER
  } state_e;

  typedef struct packed {
    logic   cfgLoad;
    logic   tmrLoad;
    phase_e tmrSel;
    logic   cmdTake;
  } strobe_t;

endpackage

// File: rtl/pdseq_dp.sv
module pdseq_dp
  import pdseq_pkg::*;
#(
  parameter int unsigned TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [1:0]       cmdType,
  input  strobe_t          stb,
  output logic             tmrDone,
  output logic             entryOk
);

  function automatic logic [TMR_W-1:0] fieldOf(input logic [CFG_W-1:0] w,
                                                 input int unsigned lsb,
                                                 input int unsigned wd);
    logic [CFG_W-1:0] s;
    logic [TMR_W-1:0] r;
    s = w >> lsb;
    for (int i = 0; i < int'(TMR_W); i++) r[i] = (i < int'(wd)) ? s[i] : 1'b0;
    return r;
  endfunction

  logic [CFG_W-1:0] cfgQ, cfgUse;
  logic [TMR_W-1:0] phVal, loadVal, tmrQ, cshV, cacV;

  // Live word while idle, frozen copy once a sequence is running
  assign cfgUse = stb.cfgLoad ? cfgWord : cfgQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfgQ <= '0;
    else if (stb.cfgLoad) cfgQ <= cfgWord;
  end

  assign cshV = fieldOf(cfgUse, F_CSH_LSB, F_CSH_W);
  assign cacV = fieldOf(cfgUse, F_CACSH_LSB, F_CACSH_W);

  always_comb begin
    case (stb.tmrSel)
      PH_CPDED:  phVal = fieldOf(cfgUse, F_CPD_LSB, F_CPD_W);
      PH_CKE:    phVal = fieldOf(cfgUse, F_CKE_LSB, F_CKE_W);
      PH_CKCKEH: phVal = fieldOf(cfgUse, F_CKH_LSB, F_CKH_W);
      PH_CACSH:  phVal = cacV;
      PH_CSL:    phVal = fieldOf(cfgUse, F_CSL_LSB, F_CSL_W);
      PH_CSHI:   phVal = (cshV > cacV) ? cshV : cacV;
      PH_XP:     phVal = fieldOf(cfgUse, F_XP_LSB, F_XP_W);
      default:   phVal = '0;
    endcase
  end

  // A phase lasts max(value,1) cycles: load value-1, finish at zero
  assign loadVal = (phVal == '0) ? '0 : phVal - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tmrQ <= '0;
    else if (stb.tmrLoad)   tmrQ <= loadVal;
    else if (tmrQ != '0)    tmrQ <= tmrQ - 1'b1;
  end

  assign tmrDone = (tmrQ == '0);

  // Per-kind entry delay counters
  logic [TMR_W-1:0]     entVal [NUM_KINDS];
  logic [NUM_KINDS-1:0] entHit, entZero;

  assign entVal[0] = fieldOf(cfgUse, F_RD_LSB, F_RD_W);
  assign entVal[1] = fieldOf(cfgUse, F_WR_LSB, F_WR_W);
  assign entVal[2] = fieldOf(cfgUse, F_PR_LSB, F_PR_W);

  assign entHit[0] = stb.cmdTake && (cmdType == CMD_RD);
  assign entHit[1] = stb.cmdTake && (cmdType == CMD_WR);
  assign entHit[2] = stb.cmdTake && cmdType[1];

  for (genvar g = 0; g < int'(NUM_KINDS); g++) begin : g_ent
    logic [TMR_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cntQ <= '0;
      else if (entHit[g])    cntQ <= entVal[g];
      else if (cntQ != '0)   cntQ <= cntQ - 1'b1;
    end
    assign entZero[g] = (cntQ == '0);
  end

  assign entryOk = &entZero;

endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmdValid,
  input  logic    pdReq,
  input  logic    wakeReq,
  input  logic    tmrDone,
  input  logic    entryOk,
  output strobe_t stb,
  output logic    pdActive,
  output logic    csN,
  output logic    caHold,
  output logic    cmdAllow
);

  state_e stateQ, nextSt;
  logic   pdPend, wakePend, goDown, wakeNow;

  assign goDown  = (stateQ == ST_IDLE) && (pdReq || pdPend) && entryOk && !cmdValid;
  assign wakeNow = wakeReq || wakePend;

  always_comb begin
    nextSt      = stateQ;
    stb.cfgLoad = (stateQ == ST_IDLE);
    stb.cmdTake = (stateQ == ST_IDLE) && cmdValid;
    stb.tmrLoad = 1'b0;
    stb.tmrSel  = PH_CPDED;
    case (stateQ)
      ST_IDLE:    if (goDown)             begin nextSt = ST_ENTER;   stb.tmrLoad = 1'b1; stb.tmrSel = PH_CPDED;  end
      ST_ENTER:   if (tmrDone)            begin nextSt = ST_DOWN;    stb.tmrLoad = 1'b1; stb.tmrSel = PH_CKE;    end
      ST_DOWN:    if (tmrDone && wakeNow) begin nextSt = ST_CLKWAIT; stb.tmrLoad = 1'b1; stb.tmrSel = PH_CKCKEH; end
      ST_CLKWAIT: if (tmrDone)            begin nextSt = ST_SETUP;   stb.tmrLoad = 1'b1; stb.tmrSel = PH_CACSH;  end
      ST_SETUP:   if (tmrDone)            begin nextSt = ST_CSLOW;   stb.tmrLoad = 1'b1; stb.tmrSel = PH_CSL;    end
      ST_CSLOW:   if (tmrDone)            begin nextSt = ST_CSHIGH;  stb.tmrLoad = 1'b1; stb.tmrSel = PH_CSHI;   end
      ST_CSHIGH:  if (tmrDone)            begin nextSt = ST_RECOVER; stb.tmrLoad = 1'b1; stb.tmrSel = PH_XP;     end
      ST_RECOVER: if (tmrDone)            nextSt = ST_IDLE;
      default:                            nextSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      pdPend   <= 1'b0;
      wakePend <= 1'b0;
    end else begin
      stateQ <= nextSt;
      if (stateQ == ST_IDLE && !goDown) pdPend <= pdPend || pdReq;
      else                              pdPend <= 1'b0;
      if ((stateQ == ST_ENTER || stateQ == ST_DOWN) && nextSt != ST_CLKWAIT)
        wakePend <= wakeNow;
      else
        wakePend <= 1'b0;
    end
  end

  assign cmdAllow = (stateQ == ST_IDLE);
  assign pdActive = (stateQ != ST_IDLE) && (stateQ != ST_RECOVER);
  assign csN      = (stateQ != ST_CSLOW);
  assign caHold   = (stateQ == ST_SETUP) || (stateQ == ST_CSLOW) || (stateQ == ST_CSHIGH);

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int unsigned TMR_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cfg_word,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_type,
  input  logic        pd_req,
  input  logic        wake_req,
  output logic        pd_active,
  output logic        cs_n,
  output logic        ca_hold,
  output logic        cmd_allow
);

  strobe_t stb;
  logic    tmrDone, entryOk;

  pdseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmd_valid),
    .pdReq    (pd_req),
    .wakeReq  (wake_req),
    .tmrDone  (tmrDone),
    .entryOk  (entryOk),
    .stb      (stb),
    .pdActive (pd_active),
    .csN      (cs_n),
    .caHold   (ca_hold),
    .cmdAllow (cmd_allow)
  );

  pdseq_dp #(.TMR_W(TMR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfgWord (cfg_word),
    .cmdType (cmd_type),
    .stb     (stb),
    .tmrDone (tmrDone),
    .entryOk (entryOk)
  );

endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic pd_active,
  input logic cs_n,
  input logic ca_hold,
  input logic cmd_allow
);

  p_cs_low_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (ca_hold && pd_active));

  p_blocked_in_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !cmd_allow);

  p_setup_before_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(ca_hold));

  p_hold_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ca_hold);

  p_hold_within_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ca_hold |-> pd_active);

  p_entry_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> ($past(cmd_allow) && !$past(cmd_valid)));

  p_recovery_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_allow) |-> !$past(pd_active));

endmodule

bind pdseq_top pdseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .pd_active (pd_active),
  .cs_n      (cs_n),
  .ca_hold   (ca_hold),
  .cmd_allow (cmd_allow)
);

// File: tb/pdseq_top_tb.sv
`timescale 1ns/1ps
module pdseq_top_tb;

  typedef struct packed {
    logic [1:0] ct;
    logic [4:0] pr;
    logic [4:0] cacsh;
    logic [5:0] csl;
    logic [5:0] csh;
    logic [4:0] ckh;
    logic [9:0] wr;
    logic [7:0] rd;
    logic [4:0] cpd;
    logic [6:0] xp;
    logic [6:0] cke;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd1,  5'd4,  6'd4,  6'd4,  5'd8,  10'd4,    8'd4,   5'd1,  7'd4,   7'd4},
    '{2'd1, 5'd3,  5'd2,  6'd6,  6'd3,  5'd3,  10'd1023, 8'd2,   5'd2,  7'd5,   7'd6},
    '{2'd2, 5'd31, 5'd7,  6'd1,  6'd2,  5'd0,  10'd0,    8'd0,   5'd0,  7'd0,   7'd0},
    '{2'd3, 5'd0,  5'd0,  6'd0,  6'd0,  5'd31, 10'd5,    8'd200, 5'd31, 7'd127, 7'd127},
    '{2'd0, 5'd1,  5'd31, 6'd63, 6'd63, 5'd1,  10'd1,    8'd255, 5'd3,  7'd2,   7'd9},
    '{2'd1, 5'd9,  5'd3,  6'd2,  6'd5,  5'd2,  10'd0,    8'd9,   5'd1,  7'd3,   7'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_word = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_type = 2'b00;
  logic        pd_req = 1'b0;
  logic        wake_req = 1'b0;
  logic        pd_active, cs_n, ca_hold, cmd_allow;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pdseq_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .pd_req    (pd_req),
    .wake_req  (wake_req),
    .pd_active (pd_active),
    .cs_n      (cs_n),
    .ca_hold   (ca_hold),
    .cmd_allow (cmd_allow)
  );

  function automatic logic [63:0] pack(input vec_t v);
    return {v.pr, v.cacsh, v.csl, v.csh, v.ckh, v.wr, v.rd, v.cpd, v.xp, v.cke};
  endfunction

  function automatic int one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic logic condNow(input int kind);
    case (kind)
      0:       return pd_active && !ca_hold && cs_n;
      1:       return ca_hold && cs_n;
      2:       return !cs_n;
      3:       return ca_hold && cs_n;
      default: return !pd_active && !cmd_allow;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runLen(input int kind, output int n);
    n = 0;
    while (condNow(kind) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitEntry(output int n);
    n = 0;
    do begin
      @(negedge clk);
      pd_req = 1'b0;
      n++;
    end while (!pd_active && n < 3000);
  endtask

  task automatic finishExit();
    int n;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    n = 0;
    while (!cmd_allow && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R10 idle again", int'(cmd_allow), 1);
  endtask

  task automatic runVec(input vec_t v);
    int n, m, nEnt;
    string tag;
    cfg_word = pack(v);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_type  = v.ct;
    @(negedge clk);
    cmd_valid = 1'b0;
    pd_req    = 1'b1;
    waitEntry(n);
    nEnt = (v.ct == 2'd0) ? int'(v.rd) : (v.ct == 2'd1) ? int'(v.wr) : int'(v.pr);
    tag  = (v.ct == 2'd0) ? "R2 read entry" : (v.ct == 2'd1) ? "R3 write entry" : "R4 other entry (R11)";
    chk(tag, n, nEnt + 1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    runLen(0, m);
    chk("R6/R7 down+clock wait", m + 1, one(int'(v.cpd)) + one(int'(v.cke)) + one(int'(v.ckh)));
    runLen(1, m);
    chk("R7 setup", m, one(int'(v.cacsh)));
    runLen(2, m);
    chk("R8 cs low", m, one(int'(v.csl)));
    runLen(3, m);
    chk("R9 cs high", m, one((v.csh > {1'b0, v.cacsh}) ? int'(v.csh) : int'(v.cacsh)));
    runLen(4, m);
    chk("R10 recovery", m, one(int'(v.xp)));
    chk("R10 allow", int'(cmd_allow), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R1-all actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    vec_t d, a;
    int n, m;
    repeat (3) @(negedge clk);
    chk("R1 allow in reset", int'(cmd_allow), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd_allow", int'(cmd_allow), 1);
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 pd_active", int'(pd_active), 0);
    chk("R1 ca_hold", int'(ca_hold), 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // Late wake, ignored stimulus while blocked (R6, R12)
    d = VECS[0];
    cfg_word = pack(d);
    repeat (3) @(negedge clk);
    pd_req = 1'b1;
    waitEntry(n);
    chk("R11 entry with no delay", n, 1);
    a = d; a.csl = 6'd10; a.rd = 8'd200;
    for (int c = 0; c < 40; c++) begin
      if (c == 5) begin cfg_word = pack(a); cmd_valid = 1'b1; cmd_type = 2'b00; pd_req = 1'b1; end
      else begin cmd_valid = 1'b0; pd_req = 1'b0; end
      @(negedge clk);
    end
    chk("R6 held without wake", int'(pd_active), 1);
    chk("R6 cs_n high", int'(cs_n), 1);
    chk("R6 blocked", int'(cmd_allow), 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    runLen(0, m);
    chk("R7 clock wait after late wake", m, 8);
    runLen(1, m);
    chk("R7 setup late", m, 4);
    runLen(2, m);
    chk("R12 old cs low width kept", m, 4);
    runLen(3, m);
    runLen(4, m);
    chk("R10 late recovery", m, 4);
    pd_req = 1'b1;
    waitEntry(n);
    chk("R12 blocked read did not delay entry", n, 1);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    runLen(0, m);
    runLen(1, m);
    runLen(2, m);
    chk("R12 new cs low width applied", m, 10);
    runLen(3, m);
    runLen(4, m);

    // Delay restarted by a later command (R5)
    d = VECS[0]; d.rd = 8'd6; d.pr = 5'd2;
    cfg_word = pack(d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = 2'b00;
    @(negedge clk);
    cmd_valid = 1'b0; pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    n = 1;
    chk("R5 request waits", int'(pd_active), 0);
    while (!pd_active && n < 200) begin
      if (n == 5) begin cmd_valid = 1'b1; cmd_type = 2'b10; end
      else cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    chk("R5 later command extends wait", n, 9);
    finishExit();

    // Request in the same cycle as a command (R5)
    d = VECS[2]; d.pr = 5'd0;
    cfg_word = pack(d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = 2'b11; pd_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; pd_req = 1'b0;
    chk("R5 no entry with command", int'(pd_active), 0);
    @(negedge clk);
    chk("R5 entry next cycle", int'(pd_active), 1);
    finishExit();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule